// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-wire serial link. The three wires are an active-high select, a serial clock and one bidirectional data line. The data line is split into an input, an output and an output enable, so a pad or an FPGA I/O buffer can join them. Behind the link sits an array of eight byte-wide registers. An external master raises the select and clocks in a command byte. It then either clocks in write data or clocks out read data.

The command byte gives the direction, the register number and whether one register or all eight are moved. The top bit of register 7 is a write-protect flag. It blocks writes to the other registers. In an all-register transfer it can never change. The serial clock, select and data line are brought into a faster system clock through two-flop synchronizers, and their edges are detected there. The system clock must run at least eight times faster than the serial clock.

Top module: `tw_reg_port`

## Requirements
- R1: After synchronous reset every register holds 0x00 and `sd_oe` is low.
- R2: A command byte is the first 8 bits after select rises, shifted in LSB first. Bit 0 is the direction (0 write, 1 read) and bits 3:1 give the register number. If bit 7 is 0, the command is ignored: no register changes and `sd_oe` stays low until select falls.
- R3: A command matching 1001xxx1 (bits 7:4 = 1001, bit 0 = 1) is ignored. No register changes and `sd_oe` stays low until select falls.
- R4: Data bits are captured on serial-clock rising edges, LSB first. A single write commits on the 8th data bit, and any later clocks in that transfer change nothing.
- R5: Read data is driven on serial-clock falling edges, LSB first. Bit 0 appears on the first falling edge after the last command bit. In a single read, further clocks send the same register again.
- R6: Commands 0xBE and 0xBF are an all-register write and read. Registers 0 to 7 are moved in ascending order, starting with bit 0 of register 0. A read that goes past register 7 continues with register 0.
- R7: While select is low, `sd_oe` is low within 4 system clocks. A byte left incomplete when select falls is discarded.
- R8: In an all-register write, each byte is written when its 8th bit is captured. Bytes that completed earlier are kept even if select falls later.
- R9: While register 7 bit 7 (write protect) is 1, writes to registers 0 to 6 are blocked. A single write to register 7 always takes effect.
- R10: An all-register write never changes register 7 bit 7. It writes register 7 bits 6:0 only when write protect is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | Link select, active high (asynchronous) |
| ser_clk | input | 1 | Serial clock (asynchronous) |
| sd_in | input | 1 | Data line as seen at the pad (asynchronous) |
| sd_out | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |

## Verification
The assertions assume that the serial clock and select are clean, with no glitches. They also assume each level lasts well over four system clocks, and that the data line is stable around every rising serial edge. The synchronizer delay may then shift edges but never drops or merges them. The bench master holds every serial level for eight system clocks and changes the data line only while the serial clock is low. It samples read data just before each rising edge, as a real master would. Its reference model compares `sd_oe` and `sd_out` on every clock once the lines have been still for six clocks.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int TW_BYTE = 8;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_HOLD
  } tw_state_e;

  // Factory test pattern: upper nibble 1001 with the read bit set.
  function automatic logic cmd_is_test(input logic [TW_BYTE-1:0] c);
    return (c[7:4] == 4'b1001) && c[0];
  endfunction

  // All-register transfer: bits 5:1 all ones.
  function automatic logic cmd_is_all(input logic [TW_BYTE-1:0] c);
    return &c[5:1];
  endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q_now,
  output logic [WIDTH-1:0] q_prev
);
  logic [STAGES:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], d};
  end

  assign q_now  = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/tw_regs.sv
module tw_regs #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          wp
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
  assign wp    = mem[DEPTH-1][DW-1];
endmodule

// File: rtl/tw_engine.sv
module tw_engine
  import tw_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_s,
  input  logic               clk_rise,
  input  logic               clk_fall,
  input  logic               din_s,
  input  logic               wp,
  input  logic [TW_BYTE-1:0] rdata,
  output logic [AW-1:0]      addr,
  output logic               we,
  output logic [TW_BYTE-1:0] wdata,
  output logic               all_mode,
  output logic               sd_out,
  output logic               sd_oe
);
  localparam int          BW        = $clog2(TW_BYTE);
  localparam logic [BW-1:0] LAST_BIT  = BW'(TW_BYTE - 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'((1 << AW) - 1);

  tw_state_e          st;
  logic [TW_BYTE-2:0] sh;
  logic [BW-1:0]      bcnt;
  logic [TW_BYTE-1:0] nxt;
  logic               byte_done;
  logic               cmd_ok;

  assign nxt       = {din_s, sh};
  assign byte_done = clk_rise && (bcnt == LAST_BIT);
  assign cmd_ok    = nxt[TW_BYTE-1] && !cmd_is_test(nxt);

  always_comb begin
    we    = 1'b0;
    wdata = nxt;
    if (st == ST_WR && byte_done) begin
      if (addr == LAST_ADDR) begin
        we = !all_mode || !wp;
        if (all_mode) wdata = {wp, nxt[TW_BYTE-2:0]};
      end else begin
        we = !wp;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_CMD;
      sh       <= '0;
      bcnt     <= '0;
      addr     <= '0;
      all_mode <= 1'b0;
      sd_out   <= 1'b0;
      sd_oe    <= 1'b0;
    end else if (!en_s) begin
      st       <= ST_CMD;
      bcnt     <= '0;
      all_mode <= 1'b0;
      sd_oe    <= 1'b0;
    end else begin
      if (clk_rise && (st == ST_CMD || st == ST_WR)) begin
        sh   <= nxt[TW_BYTE-1:1];
        bcnt <= bcnt + 1'b1;
      end
      case (st)
        ST_CMD: if (byte_done) begin
          if (!cmd_ok) begin
            st <= ST_HOLD;
          end else begin
            all_mode <= cmd_is_all(nxt);
            addr     <= cmd_is_all(nxt) ? '0 : nxt[AW:1];
            st       <= nxt[0] ? ST_RD : ST_WR;
          end
        end
        ST_WR: if (byte_done) begin
          if (all_mode && addr != LAST_ADDR) addr <= addr + 1'b1;
          else                               st   <= ST_HOLD;
        end
        ST_RD: if (clk_fall) begin
          sd_oe  <= 1'b1;
          sd_out <= rdata[bcnt];
          bcnt   <= bcnt + 1'b1;
          if (all_mode && bcnt == LAST_BIT) addr <= addr + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tw_reg_port.sv
module tw_reg_port
  import tw_pkg::*;
#(
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_en,
  input  logic ser_clk,
  input  logic sd_in,
  output logic sd_out,
  output logic sd_oe
);
  logic [2:0]         s_now, s_prev;
  logic               clk_rise, clk_fall;
  logic               we, wp, all_mode;
  logic [AW-1:0]      addr;
  logic [TW_BYTE-1:0] wdata, rdata;

  tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({sd_in, ser_en, ser_clk}),
    .q_now(s_now), .q_prev(s_prev)
  );

  assign clk_rise = s_now[0] && !s_prev[0];
  assign clk_fall = !s_now[0] && s_prev[0];

  tw_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst(rst), .en_s(s_now[1]), .clk_rise(clk_rise),
    .clk_fall(clk_fall), .din_s(s_now[2]), .wp(wp), .rdata(rdata),
    .addr(addr), .we(we), .wdata(wdata), .all_mode(all_mode),
    .sd_out(sd_out), .sd_oe(sd_oe)
  );

  tw_regs #(.AW(AW), .DW(TW_BYTE)) u_regs (
    .clk(clk), .rst(rst), .we(we), .waddr(addr), .wdata(wdata),
    .raddr(addr), .rdata(rdata), .wp(wp)
  );
endmodule

// File: rtl/tw_chk.sv
module tw_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          ser_en,
  input logic          sd_oe,
  input logic          sd_out,
  input logic          clk_rise,
  input logic          clk_fall,
  input logic          we,
  input logic [AW-1:0] waddr,
  input logic [7:0]    wdata,
  input logic          wp,
  input logic          all_mode
);
  localparam logic [AW-1:0] LAST_ADDR = AW'((1 << AW) - 1);

  logic [2:0] low_cnt;
  always_ff @(posedge clk) begin
    if (rst || ser_en) low_cnt <= '0;
    else if (low_cnt != 3'd7) low_cnt <= low_cnt + 1'b1;
  end

  a_r7_oe_released: assert property (@(posedge clk) disable iff (rst)
    (low_cnt >= 3'd4) |-> !sd_oe);

  a_r5_out_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_out) |-> $past(clk_fall));

  a_r4_write_on_rise: assert property (@(posedge clk) disable iff (rst)
    we |-> clk_rise);

  a_r9_protect_blocks: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != LAST_ADDR) |-> !wp);

  a_r10_all_keeps_wp: assert property (@(posedge clk) disable iff (rst)
    (we && all_mode && waddr == LAST_ADDR) |-> (wdata[7] == wp && !wp));
endmodule

bind tw_reg_port tw_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ser_en(ser_en), .sd_oe(sd_oe), .sd_out(sd_out),
  .clk_rise(clk_rise), .clk_fall(clk_fall), .we(we), .waddr(addr),
  .wdata(wdata), .wp(wp), .all_mode(all_mode)
);

// File: tb/sim_tw_reg_port.sv
module sim_tw_reg_port;
  localparam int H = 8;

  logic clk = 0, rst = 1;
  logic ser_en = 0, ser_clk = 0, sd_in = 0;
  logic sd_out, sd_oe;

  tw_reg_port u0 (.clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk),
                  .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, settle = 0;
  logic [7:0] ref_m [8];
  logic m_oe = 0, m_bit = 0, pc = 0, pe = 0, done = 0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // Reference model compared on every clock once the serial lines are still.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (ser_clk !== pc || ser_en !== pe) settle = 0;
      else if (settle < 100) settle++;
      pc = ser_clk; pe = ser_en;
      if (settle >= 6) begin
        check("R7/R2/R3 output enable", sd_oe, m_oe);
        if (m_oe) check("R5 read bit", sd_out, m_bit);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog (R1..) cycles=%0d expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start();
    ser_en = 1; tick(H);
  endtask

  task automatic stop();
    ser_clk = 0; ser_en = 0; m_oe = 0; tick(2*H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sd_in = b[i]; tick(H); ser_clk = 1; tick(H); ser_clk = 0;
    end
  endtask

  task automatic send(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic recv(input logic [7:0] e, input string tag);
    logic [7:0] g;
    m_oe = 1; m_bit = e[0];
    for (int i = 0; i < 8; i++) begin
      tick(H); g[i] = sd_out; ser_clk = 1; tick(H); ser_clk = 0;
      if (i < 7) m_bit = e[i+1];
    end
    check(tag, g, e);
  endtask

  task automatic model_wr(input int a, input logic [7:0] d, input bit all);
    logic wpv;
    wpv = ref_m[7][7];
    if (a == 7) begin
      if (!all) ref_m[7] = d;
      else if (!wpv) ref_m[7] = {wpv, d[6:0]};
    end else if (!wpv) begin
      ref_m[a] = d;
    end
  endtask

  task automatic wr_single(input int a, input logic [7:0] d, input int extra);
    start();
    send({4'b1000, 3'(a), 1'b0});
    send(d);
    if (extra > 0) send_bits(~d, extra);
    stop();
    model_wr(a, d, 0);
  endtask

  task automatic rd_single(input int a, input int n, input string tag);
    start();
    send({4'b1000, 3'(a), 1'b1});
    for (int k = 0; k < n; k++) recv(ref_m[a], tag);
    stop();
  endtask

  task automatic rd_all(input int n, input string tag);
    start();
    send(8'hBF);
    for (int k = 0; k < n; k++) recv(ref_m[k % 8], tag);
    stop();
  endtask

  task automatic wr_all(input logic [7:0] base, input int nbytes, input int part);
    start();
    send(8'hBE);
    for (int k = 0; k < nbytes; k++) begin
      send(base + 8'(k * 17));
      model_wr(k, base + 8'(k * 17), 1);
    end
    if (part > 0) send_bits(8'h5A, part);
    stop();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) ref_m[i] = 8'h00;
    tick(5); rst = 0; tick(2);
    check("R1 oe after reset", sd_oe, 0);
    rd_all(8, "R1 reset contents");

    // R4/R5/R2: single writes and reads to every register
    wr_single(7, 8'h00, 0);
    for (int a = 0; a < 7; a++) wr_single(a, 8'h31 + 8'(a * 9), 0);
    for (int a = 0; a < 8; a++) rd_single(a, 1, "R2 R4 single write/read");

    // R5: extra clocks re-send the same byte
    rd_single(2, 3, "R5 resend");
    // R4: clocks after the data byte are ignored
    wr_single(3, 8'hC6, 5);
    rd_single(3, 1, "R4 extra clocks ignored");

    // R6/R8/R10: all-register write with bit 7 set in the register 7 byte
    wr_all(8'h11, 8, 0);
    rd_all(9, "R6 R10 all-register read with wrap");

    // R9: protect on blocks single writes to 0..6
    wr_single(7, 8'h80, 0);
    wr_single(1, 8'hAA, 0);
    rd_single(1, 1, "R9 protected write blocked");
    // R10: all-register write under protection changes nothing
    wr_all(8'hE0, 8, 0);
    rd_all(8, "R10 protected all-register write");
    // R9: register 7 single write clears protection
    wr_single(7, 8'h03, 0);
    wr_single(1, 8'hAA, 0);
    rd_single(1, 1, "R9 write after unprotect");
    rd_single(7, 1, "R9 register 7 value");

    // R3: test-mode command ignored
    start(); send(8'h93); send(8'h00); send(8'hFF); stop();
    rd_all(8, "R3 test command ignored");
    // R2: command with bit 7 clear ignored
    start(); send(8'h02); send(8'hFF); send(8'hFF); stop();
    start(); send(8'h01); send(8'hFF); stop();
    rd_all(8, "R2 bit7 clear ignored");

    // R8/R7: select drops inside the fourth byte of an all-register write
    wr_all(8'hA1, 3, 4);
    rd_all(8, "R8 R7 partial all-register write");

    // R7: select drops during a read
    start(); send(8'h81); recv(ref_m[0], "R5 read before drop");
    ser_en = 0; m_oe = 0; tick(6);
    check("R7 oe released after drop", sd_oe, 0);
    tick(2*H);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule